// File: doc/BRIEF.md
# LED Blink Controller with Auto-Stop

This block drives one indicator output with a programmable on/off waveform. A prescaler turns the system clock into a slow tick. The rate of that tick is chosen by an exponent code, not by a divisor. On each tick a period counter advances. The output is high during the first part of each period, up to a duty threshold, and low for the rest of it.

An optional auto-stop counter counts completed periods. After a programmed number of them it switches the waveform off by itself and raises a sticky flag. That flag drives an interrupt line unless a mask bit hides it.

Software reaches the block through four word registers, all writable and readable:

| Word index | Register | Width |
|---|---|---|
| 0 | control | 7 bits |
| 1 | period | 12 bits |
| 2 | duty | 12 bits |
| 3 | stop count | 16 bits |

Each register takes the low bits of the write data. Read data comes back one clock after the index is presented. The LED and interrupt outputs are both registered.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset `led_out`, `irq_out` and `bus_rdata` are 0, and every register reads back as 0.
- R2: A write with `bus_we`=1 stores the low bits of `bus_wdata` into the register chosen by `bus_addr`: 0 = control (7 bits), 1 = period (12 bits), 2 = duty (12 bits), 3 = stop count (16 bits). `bus_rdata` presents the register chosen by `bus_addr` one clock later, zero-extended.
- R3: The control bits [3:0] hold the time-base code k. One tick occurs every 2^(k+1) clocks while running. Codes 14 and 15 behave as 13.
- R4: On each tick the period counter steps through 0 to period-1 and then wraps, with a period of 0 acting as 1. `led_out` is high while the counter is below duty, and it lags the internal state by one clock.
- R5: A duty greater than or equal to period holds `led_out` constantly high while running. A duty of 0 with a nonzero period holds it low.
- R6: Control bit 4 is the run enable. While it is 0, `led_out` is 0 and the prescaler, period counter and stop counter are held at zero.
- R7: Any write to period, duty or stop count restarts the prescaler, the period counter and the stop counter at zero.
- R8: With control bit 5 (auto-stop) set, each period wrap is counted. On the wrap that brings the count to the stop value, the block clears control bit 4, sets the flag, and `led_out` falls.
- R9: With auto-stop set and a stop value of 0, the block never stops.
- R10: The flag is sticky until the stop count register is written. Control bit 6 masks it. `irq_out` equals flag AND NOT mask, registered one clock later.
- R11: With auto-stop clear, the waveform runs indefinitely, and control reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| led_out | output | 1 | Registered LED waveform |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The waveform is run with several period and duty pairs. A short period with mid duty checks the compare point and the wrap. A duty equal to or above the period separates the always-on case from an off-by-one compare. A duty of 0 confirms the output stays dark.

Time-base codes 0, 2 and the clamped code 15 show the tick spacing. Rewriting duty in mid-period shows the restart.

Auto-stop is tried in three settings: with the interrupt unmasked, with it masked and then unmasked, and with a stop value of 0. Together these tell the sticky flag, the masking and the never-stop case apart.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int CTRL_W = 7;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_DUTY   = 2'd2,
    SEL_STOP   = 2'd3
  } reg_sel_e;

  // control word, bit 6 down to bit 0
  typedef struct packed {
    logic       irq_mask;
    logic       auto_stop;
    logic       run;
    logic [3:0] tb_code;
  } ctrl_t;
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_blink_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stop_hit,
  output ctrl_t             ctrl_q,
  output logic [PER_W-1:0]  period_q,
  output logic [PER_W-1:0]  duty_q,
  output logic [STOP_W-1:0] stop_q,
  output logic              flag_q,
  output logic              restart,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_mux;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign restart = wr_en && (sel != SEL_CTRL);

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
      SEL_PERIOD: rd_mux[PER_W-1:0]  = period_q;
      SEL_DUTY:   rd_mux[PER_W-1:0]  = duty_q;
      SEL_STOP:   rd_mux[STOP_W-1:0] = stop_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      duty_q   <= '0;
      stop_q   <= '0;
      flag_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (ctrl_wr)
        ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (stop_hit)
        ctrl_q.run <= 1'b0;
      if (wr_en && sel == SEL_PERIOD) period_q <= wdata[PER_W-1:0];
      if (wr_en && sel == SEL_DUTY)   duty_q   <= wdata[PER_W-1:0];
      if (wr_en && sel == SEL_STOP)   stop_q   <= wdata[STOP_W-1:0];
      if (stop_hit)
        flag_q <= 1'b1;
      else if (wr_en && sel == SEL_STOP)
        flag_q <= 1'b0;
      rdata_q <= rd_mux;
    end
  end

  // R8
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_hit && !ctrl_wr) |=> (!ctrl_q.run && flag_q));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_STOP && !stop_hit) |=> !flag_q);
endmodule

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = CODE_MAX + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim_tab [0:CODE_MAX];
  logic [CODE_W-1:0] code_eff;
  logic [CNT_W-1:0]  limit;

  for (genvar g = 0; g <= CODE_MAX; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((64'd1 << (g + 1)) - 64'd1);
  end

  assign code_eff = (code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code;
  assign limit    = lim_tab[code_eff];
  assign tick     = run && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (!run || restart || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/led_wave.sv
module led_wave #(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              tick,
  input  logic              auto_stop,
  input  logic [PER_W-1:0]  period,
  input  logic [PER_W-1:0]  duty,
  input  logic [STOP_W-1:0] stop,
  output logic              led_on,
  output logic              stop_hit
);
  logic [PER_W-1:0]  pcnt_q;
  logic [STOP_W-1:0] dcnt_q;
  logic [PER_W-1:0]  last_pos;
  logic              wrap;

  assign last_pos = (period == '0) ? '0 : period - 1'b1;
  assign wrap     = tick && (pcnt_q >= last_pos);
  assign stop_hit = wrap && auto_stop &&
                    (({1'b0, dcnt_q} + 1'b1) == {1'b0, stop});
  assign led_on   = run && ((pcnt_q < duty) || (duty >= period));

  always_ff @(posedge clk) begin
    if (rst)
      pcnt_q <= '0;
    else if (!run || restart)
      pcnt_q <= '0;
    else if (tick)
      pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      dcnt_q <= '0;
    else if (!run || restart || !auto_stop || stop_hit)
      dcnt_q <= '0;
    else if (wrap)
      dcnt_q <= dcnt_q + 1'b1;
  end

  // R4
  pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (pcnt_q < period));

  // R8
  stop_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    stop_hit |=> (dcnt_q == '0));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt_q == '0 && dcnt_q == '0));
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int PER_W    = 12,
  parameter int STOP_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CODE_MAX = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              led_out,
  output logic              irq_out
);
  ctrl_t             ctrl_q;
  logic [PER_W-1:0]  period_q;
  logic [PER_W-1:0]  duty_q;
  logic [STOP_W-1:0] stop_q;
  logic              flag_q;
  logic              restart;
  logic              tick;
  logic              led_on;
  logic              stop_hit;
  logic              led_q;
  logic              irq_q;

  led_regs #(.PER_W(PER_W), .STOP_W(STOP_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_we),
    .sel      (reg_sel_e'(bus_addr)),
    .wdata    (bus_wdata),
    .stop_hit (stop_hit),
    .ctrl_q   (ctrl_q),
    .period_q (period_q),
    .duty_q   (duty_q),
    .stop_q   (stop_q),
    .flag_q   (flag_q),
    .restart  (restart),
    .rdata_q  (bus_rdata)
  );

  led_prescaler #(.CODE_W(4), .CODE_MAX(CODE_MAX)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .restart (restart),
    .code    (ctrl_q.tb_code),
    .tick    (tick)
  );

  led_wave #(.PER_W(PER_W), .STOP_W(STOP_W)) u_wave (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q.run),
    .restart   (restart),
    .tick      (tick),
    .auto_stop (ctrl_q.auto_stop),
    .period    (period_q),
    .duty      (duty_q),
    .stop      (stop_q),
    .led_on    (led_on),
    .stop_hit  (stop_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      led_q <= led_on;
      irq_q <= flag_q & ~ctrl_q.irq_mask;
    end
  end

  assign led_out = led_q;
  assign irq_out = irq_q;

  // R6
  led_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    led_out |-> $past(ctrl_q.run));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(flag_q) && !$past(ctrl_q.irq_mask)));
endmodule

// File: tb/led_blink_ctrl_tb.sv
module led_blink_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        led, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_code, m_en, m_ast, m_msk, m_per, m_duty, m_stop;
  int m_pre, m_pcnt, m_dcnt, m_flag, m_led, m_irq, m_rdata;
  int lim, eff_per, n_led, n_irq, n_rd;
  bit tick, wrap, hit, rs, run;

  always #10 clk = ~clk;

  led_blink_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .led_out(led), .irq_out(irq)
  );

  function automatic int ctrl_word();
    return m_code | (m_en << 4) | (m_ast << 5) | (m_msk << 6);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_code = 0; m_en = 0; m_ast = 0; m_msk = 0; m_per = 0; m_duty = 0;
      m_stop = 0; m_pre = 0; m_pcnt = 0; m_dcnt = 0; m_flag = 0;
      m_led = 0; m_irq = 0; m_rdata = 0;
    end else begin
      run     = (m_en != 0);
      lim     = (1 << ((m_code > 13 ? 13 : m_code) + 1)) - 1;
      tick    = run && (m_pre >= lim);
      rs      = we && (addr != 2'd0);
      eff_per = (m_per == 0) ? 1 : m_per;
      wrap    = tick && (m_pcnt + 1 >= eff_per);
      hit     = wrap && (m_ast != 0) && (m_dcnt + 1 == m_stop);
      n_led   = (run && (m_pcnt < m_duty || m_duty >= m_per)) ? 1 : 0;
      n_irq   = (m_flag != 0 && m_msk == 0) ? 1 : 0;
      case (addr)
        2'd0: n_rd = ctrl_word();
        2'd1: n_rd = m_per;
        2'd2: n_rd = m_duty;
        default: n_rd = m_stop;
      endcase
      m_pre = (!run || rs || tick) ? 0 : m_pre + 1;
      if (!run || rs) m_pcnt = 0;
      else if (tick) m_pcnt = wrap ? 0 : m_pcnt + 1;
      if (!run || rs || m_ast == 0 || hit) m_dcnt = 0;
      else if (wrap) m_dcnt = m_dcnt + 1;
      if (we && addr == 2'd0) begin
        m_code = wdata & 15; m_en = (wdata >> 4) & 1;
        m_ast = (wdata >> 5) & 1; m_msk = (wdata >> 6) & 1;
      end else if (hit) m_en = 0;
      if (we && addr == 2'd1) m_per  = wdata & 16'hFFF;
      if (we && addr == 2'd2) m_duty = wdata & 16'hFFF;
      if (we && addr == 2'd3) m_stop = wdata;
      if (hit) m_flag = 1;
      else if (we && addr == 2'd3) m_flag = 0;
      m_led = n_led; m_irq = n_irq; m_rdata = n_rd;
    end
  end

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (started) begin
      checks += 3;
      if (led !== m_led[0]) begin
        errors++;
        $display("FAIL %s led_out actual=%0d expected=%0d t=%0t", cur_req, led, m_led, $time);
      end
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL %s irq_out actual=%0d expected=%0d t=%0t", cur_req, irq, m_irq, $time);
      end
      if (rdata !== m_rdata[15:0]) begin
        errors++;
        $display("FAIL %s bus_rdata actual=%0h expected=%0h t=%0t", cur_req, rdata, m_rdata, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    chk(req, int'(rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    started = 1'b1;

    cur_req = "R1";
    idle(3);
    chk("R1 led", int'(led), 0);
    chk("R1 irq", int'(irq), 0);
    rd_chk("R1 period", 2'd1, 0);
    rd_chk("R1 stop", 2'd3, 0);

    cur_req = "R2";
    wr(2'd0, 16'hFFAF);
    wr(2'd1, 16'hF123);
    wr(2'd2, 16'hFABC);
    wr(2'd3, 16'h1234);
    rd_chk("R2 ctrl", 2'd0, 'h2F);
    rd_chk("R2 period", 2'd1, 'h123);
    rd_chk("R2 duty", 2'd2, 'hABC);
    rd_chk("R2 stop", 2'd3, 'h1234);

    cur_req = "R4";
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0010);
    idle(40);

    cur_req = "R3";
    wr(2'd0, 16'h0012);
    idle(100);
    wr(2'd0, 16'h001F);
    idle(40000);

    cur_req = "R5";
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd5);
    idle(30);
    chk("R5 duty=period on", int'(led), 1);
    wr(2'd2, 16'd9);
    idle(20);
    chk("R5 duty>period on", int'(led), 1);
    wr(2'd2, 16'd0);
    idle(20);
    chk("R5 duty=0 off", int'(led), 0);

    cur_req = "R7";
    wr(2'd2, 16'd2);
    idle(7);
    wr(2'd2, 16'd3);
    idle(15);
    wr(2'd1, 16'd6);
    idle(5);

    cur_req = "R6";
    wr(2'd0, 16'h0000);
    idle(20);
    chk("R6 led off", int'(led), 0);

    cur_req = "R8";
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd1);
    wr(2'd3, 16'd4);
    wr(2'd0, 16'h0030);
    idle(40);
    rd_chk("R8 run cleared", 2'd0, 'h20);
    chk("R8 led off", int'(led), 0);
    cur_req = "R10";
    chk("R10 irq raised", int'(irq), 1);

    wr(2'd3, 16'd2);
    wr(2'd0, 16'h0070);
    idle(30);
    chk("R10 masked irq", int'(irq), 0);
    wr(2'd0, 16'h0020);
    idle(3);
    chk("R10 sticky irq", int'(irq), 1);
    wr(2'd3, 16'd2);
    idle(3);
    chk("R10 cleared irq", int'(irq), 0);

    cur_req = "R9";
    wr(2'd3, 16'd0);
    wr(2'd0, 16'h0030);
    idle(200);
    rd_chk("R9 still running", 2'd0, 'h30);

    cur_req = "R11";
    wr(2'd3, 16'd3);
    wr(2'd0, 16'h0010);
    idle(100);
    rd_chk("R11 still running", 2'd0, 'h10);
    chk("R11 irq quiet", int'(irq), 0);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule